// File: doc/BRIEF.md
# Mode-Selectable Up-Counting Timer

This block is an up-counter of parameterised width (16 bits by default) with two compare registers, called A and B. It also has a toggling output line and a one-cycle interrupt pulse. An external prescaler supplies a count enable. Separate edge-select logic supplies a strobe that is already qualified as a valid edge of an external event input. A small control register chooses how the counter behaves:

- held stopped at zero;
- free-running;
- cleared and restarted by an external edge;
- cleared and restarted when the count equals compare A.

A sticky flag records every pass of the count from all-ones to zero.

Software writes the control word and the two compare values through one parallel write port, selected by a small index. Once the timer is running, the mode field is locked against change, with two exceptions: software may still update the overflow flag, and software may always return the timer to the stopped state. One control bit widens the set of toggle sources, so that external edges toggle the output in addition to compare matches.

Top module: `mode_timer`

## Requirements
- R1: After reset, the control readback is 0x00, the count is zero, `tout` is 0 and `irq` is 0. Bits [7:4] of `ctrl_rd` always read as zero.
- R2: While control bits [3:2] are 00 (stopped), the count is held at zero one cycle later, `tout` keeps its value, and `irq` stays low.
- R3: While running (bits [3:2] not 00), every cycle with `cnt_en` high adds one to the count. All-ones wraps to zero. A cycle with `cnt_en` low leaves the count unchanged, unless the clear in R5 applies.
- R4: In mode 11 (restart on compare A), a `cnt_en` cycle whose current count equals compare A loads zero instead of incrementing. Mode 01 is free-running and has no such clear.
- R5: In mode 10 (restart on edge), a cycle with `ext_edge` high loads zero, whatever `cnt_en` is. This clear takes priority over counting.
- R6: A match event for A (or B) is a running cycle with `cnt_en` high whose current count equals that compare value. `irq` is high in the cycle that follows a cycle with any match event. Coincident A and B matches produce a single pulse.
- R7: `tout` (reset 0) inverts one cycle after a cycle holding a match event. When control bit 1 is set, it also inverts after a running cycle with `ext_edge` high. It inverts at most once per cycle, however many sources coincide.
- R8: The overflow flag (control bit 0) becomes 1 after a running `cnt_en` cycle whose count is all-ones and is not cleared by R5. This includes mode 11 with compare A at all-ones. The flag stays at 1 until software writes 0. A hardware set wins over a same-cycle write.
- R9: Write port: `wr_sel` 0 selects control, 1 selects compare A and 2 selects compare B. Compare registers reset to zero and accept writes at any time. A control write while stopped, or one whose bits [3:1] are 000, updates bits [3:1]. Any other control write while running changes only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable from prescaler |
| ext_edge | input | 1 | Qualified external edge strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 compare A, 2 compare B |
| wr_data | input | W | Write data (control uses bits [3:0]) |
| ctrl_rd | output | 8 | Control register readback |
| count | output | W | Current counter value |
| tout | output | 1 | Toggle output |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench sweeps compare A over every value of an 8-bit build in restart-on-match mode. If the clear were off by one, the counter would run one value past compare A or stop one short, and the bench catches the period error at once. Compare A at all-ones is aimed at specifically: a design that treated the match clear as something other than a wrap would leave the overflow flag clear. Coincident A, B and edge events are driven to expose a design that toggles the output twice, which leaves it unchanged, or emits two interrupt pulses. Mode writes while running, and edges arriving in the same cycle as a match, check that the lock on the mode field and the priority of the edge clear hold.

// File: rtl/mt_pkg.sv
package mt_pkg;

    typedef enum logic [1:0] {
        MODE_STOP  = 2'b00,
        MODE_FREE  = 2'b01,
        MODE_EDGE  = 2'b10,
        MODE_MATCH = 2'b11
    } mode_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CMPA = 2'd1;
    localparam logic [1:0] SEL_CMPB = 2'd2;

    localparam int NUM_CMP = 2;

endpackage

// File: rtl/mt_ctrl.sv
module mt_ctrl
    import mt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [3:0] wdata,
    input  logic       ovf_set,
    output mode_e      mode,
    output logic       edge_tog,
    output logic       ovf
);

    typedef struct packed {
        mode_e mode;
        logic  edge_tog;
        logic  ovf;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;
    logic  mode_wr_ok;

    always_comb begin
        ctrl_d     = ctrl_q;
        mode_wr_ok = (ctrl_q.mode == MODE_STOP) || (wdata[3:1] == 3'b000);
        if (wr_ctrl) begin
            if (mode_wr_ok) begin
                ctrl_d.mode     = mode_e'(wdata[3:2]);
                ctrl_d.edge_tog = wdata[1];
            end
            ctrl_d.ovf = wdata[0];
        end
        if (ovf_set) begin
            ctrl_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{mode: MODE_STOP, edge_tog: 1'b0, ovf: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign mode     = ctrl_q.mode;
    assign edge_tog = ctrl_q.edge_tog;
    assign ovf      = ctrl_q.ovf;

    // R9
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && ctrl_q.mode != MODE_STOP && wdata[3:1] != 3'b000)
        |=> (ctrl_q.mode == $past(ctrl_q.mode) && ctrl_q.edge_tog == $past(ctrl_q.edge_tog)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ovf && !wr_ctrl) |=> ctrl_q.ovf);

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ctrl_q.ovf);

endmodule

// File: rtl/mt_cmpreg.sv
module mt_cmpreg
    import mt_pkg::*;
#(
    parameter int W = 16,
    parameter int N = NUM_CMP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] cmp
);

    logic [N-1:0][W-1:0] cmp_d, cmp_q;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        localparam logic [1:0] MY_SEL = SEL_CMPA + 2'(g);

        always_comb begin
            cmp_d[g] = cmp_q[g];
            if (wr_en && wr_sel == MY_SEL) begin
                cmp_d[g] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_q[g] <= '0;
            end else begin
                cmp_q[g] <= cmp_d[g];
            end
        end

        // R9
        cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == MY_SEL) |=> $stable(cmp_q[g]));
    end

    assign cmp = cmp_q;

endmodule

// File: rtl/mt_count.sv
module mt_count
    import mt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         ext_edge,
    input  mode_e        mode,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    output logic [W-1:0] count,
    output logic         match_a,
    output logic         match_b,
    output logic         ovf_set
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;
    logic running, tick, edge_clr, at_top;

    always_comb begin
        running  = (mode != MODE_STOP);
        tick     = running && cnt_en;
        edge_clr = (mode == MODE_EDGE) && ext_edge;
        at_top   = (cnt_q.cnt == ALL_ONES);
        match_a  = tick && (cnt_q.cnt == cmp_a);
        match_b  = tick && (cnt_q.cnt == cmp_b);
        ovf_set  = tick && at_top && !edge_clr;

        cnt_d = cnt_q;
        if (!running) begin
            cnt_d.cnt = '0;
        end else if (edge_clr) begin
            cnt_d.cnt = '0;
        end else if (tick) begin
            if (mode == MODE_MATCH && match_a) begin
                cnt_d.cnt = '0;
            end else begin
                cnt_d.cnt = cnt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.cnt;

    // R2
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP) |=> (cnt_q.cnt == '0));

    // R3
    count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !edge_clr && !(mode == MODE_MATCH && match_a))
        |=> (cnt_q.cnt == W'($past(cnt_q.cnt) + 1'b1)));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cnt_en && !edge_clr) |=> $stable(cnt_q.cnt));

    // R5
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_clr |=> (cnt_q.cnt == '0));

endmodule

// File: rtl/mt_outp.sv
module mt_outp (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic match_a,
    input  logic match_b,
    input  logic ext_edge,
    input  logic edge_tog,
    output logic tout,
    output logic irq
);

    typedef struct packed {
        logic tout;
        logic irq;
    } out_s;

    out_s out_d, out_q;
    logic any_match, edge_evt, toggle;

    always_comb begin
        any_match = match_a || match_b;
        edge_evt  = running && ext_edge && edge_tog;
        toggle    = any_match || edge_evt;
        out_d.irq  = any_match;
        out_d.tout = out_q.tout ^ toggle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tout = out_q.tout;
    assign irq  = out_q.irq;

    // R7
    tout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle |=> $stable(out_q.tout));

    // R7
    tout_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (out_q.tout != $past(out_q.tout)));

endmodule

// File: rtl/mode_timer.sv
module mode_timer
    import mt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         ext_edge,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [7:0]   ctrl_rd,
    output logic [W-1:0] count,
    output logic         tout,
    output logic         irq
);

    mode_e                     mode;
    logic                      edge_tog, ovf, ovf_set;
    logic                      match_a, match_b, running, wr_ctrl;
    logic [NUM_CMP-1:0][W-1:0] cmp;

    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    assign running = (mode != MODE_STOP);

    mt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wdata    (wr_data[3:0]),
        .ovf_set  (ovf_set),
        .mode     (mode),
        .edge_tog (edge_tog),
        .ovf      (ovf)
    );

    mt_cmpreg #(.W(W), .N(NUM_CMP)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wdata  (wr_data),
        .cmp    (cmp)
    );

    mt_count #(.W(W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .ext_edge (ext_edge),
        .mode     (mode),
        .cmp_a    (cmp[0]),
        .cmp_b    (cmp[1]),
        .count    (count),
        .match_a  (match_a),
        .match_b  (match_b),
        .ovf_set  (ovf_set)
    );

    mt_outp u_outp (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .match_a  (match_a),
        .match_b  (match_b),
        .ext_edge (ext_edge),
        .edge_tog (edge_tog),
        .tout     (tout),
        .irq      (irq)
    );

    assign ctrl_rd = {4'b0000, mode, edge_tog, ovf};

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a || match_b) |=> irq);

    // R6
    irq_only_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_a || match_b) |=> !irq);

    // R2
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (!irq && $stable(tout)));

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[7:4] == 4'b0000);

endmodule

// File: tb/mode_timer_tb.sv
module mode_timer_tb_top;

    localparam int W = 8;
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         ext_edge = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [7:0]   ctrl_rd;
    logic [W-1:0] count;
    logic         tout, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // expected-state model
    logic [1:0]   m_mode = 2'b00;
    logic         m_tog = 1'b0, m_ovf = 1'b0, m_tout = 1'b0, m_irq = 1'b0;
    logic [W-1:0] m_cnt = '0, m_a = '0, m_b = '0;

    always #2 clk = ~clk;

    mode_timer #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ext_edge(ext_edge),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .count(count), .tout(tout), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_dut();
        return {ctrl_rd, count, 6'd0, tout, irq};
    endfunction

    function automatic logic [31:0] pack_model();
        return {4'b0000, m_mode, m_tog, m_ovf, m_cnt, 6'd0, m_tout, m_irq};
    endfunction

    task automatic step(input string req, input logic en, input logic edg,
                        input logic wr, input logic [1:0] sel, input logic [W-1:0] data);
        logic run, tick, ma, mb, eclr;
        logic [W-1:0] nc;
        @(negedge clk);
        cnt_en = en; ext_edge = edg; wr_en = wr; wr_sel = sel; wr_data = data;
        @(posedge clk);
        run  = (m_mode != 2'b00);
        tick = run && en;
        ma   = tick && (m_cnt == m_a);
        mb   = tick && (m_cnt == m_b);
        eclr = (m_mode == 2'b10) && edg;
        if (!run || eclr) nc = '0;
        else if (tick) nc = (m_mode == 2'b11 && ma) ? '0 : W'(m_cnt + 1);
        else nc = m_cnt;
        m_tout = m_tout ^ (ma || mb || (run && edg && m_tog));
        m_irq  = ma || mb;
        if (wr && sel == 2'd0) begin
            if (m_mode == 2'b00 || data[3:1] == 3'b000) begin
                m_mode = data[3:2];
                m_tog  = data[1];
            end
            m_ovf = data[0];
        end
        if (tick && m_cnt == TOP && !eclr) m_ovf = 1'b1;
        if (wr && sel == 2'd1) m_a = data;
        if (wr && sel == 2'd2) m_b = data;
        m_cnt = nc;
        #1;
        check(req, pack_dut(), pack_model());
    endtask

    task automatic wr(input string req, input logic [1:0] sel, input logic [W-1:0] data);
        step(req, 1'b0, 1'b0, 1'b1, sel, data);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic tprev;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", pack_dut(), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 stopped: enables and edges do nothing
        for (int i = 0; i < 20; i++) step("R2", 1'b1, i[0], 1'b0, 2'd0, '0);

        // R1 / R9 upper bits read zero, full write while stopped
        wr("R9", 2'd1, 8'd10);
        wr("R9", 2'd2, 8'd40);
        wr("R1", 2'd0, 8'hF4);
        check("R1", {24'd0, ctrl_rd}, 32'h04);

        // R3 free-running with gapped enable, two wraps, R8 overflow
        for (int i = 0; i < 800; i++) step("R3", (i % 3) != 0, 1'b0, 1'b0, 2'd0, '0);
        check("R8", {31'd0, ctrl_rd[0]}, 32'd1);
        // R9 mode write while running ignored, bit 0 cleared
        wr("R9", 2'd0, 8'h0C);
        check("R9", {24'd0, ctrl_rd}, 32'h04);

        // R7 edge toggling enabled in free-run; mode bits locked so stop first
        wr("R9", 2'd0, 8'h00);
        wr("R7", 2'd0, 8'h06);
        for (int i = 0; i < 300; i++) step("R7", 1'b1, (i % 7) == 0, 1'b0, 2'd0, '0);

        // R4 exhaustive sweep of compare A in restart-on-match mode
        wr("R4", 2'd0, 8'h00);
        wr("R4", 2'd0, 8'h0C);
        for (int c = 0; c < 256; c++) begin
            wr("R4", 2'd1, W'(c));
            wr("R6", 2'd2, W'(c / 2));
            for (int i = 0; i < 2 * (c + 1); i++) step("R4", 1'b1, 1'b0, 1'b0, 2'd0, '0);
        end
        // R8 compare A at all-ones sets the flag through the match clear
        wr("R8", 2'd0, 8'h0C);
        check("R8", {31'd0, ctrl_rd[0]}, 32'd0);
        for (int i = 0; i < 300; i++) step("R8", 1'b1, 1'b0, 1'b0, 2'd0, '0);
        check("R8", {31'd0, ctrl_rd[0]}, 32'd1);

        // R6 / R7 coincident A, B and edge: one toggle, one pulse
        wr("R7", 2'd0, 8'h00);
        wr("R7", 2'd0, 8'h0E);
        wr("R6", 2'd1, 8'd5);
        wr("R6", 2'd2, 8'd5);
        for (int i = 0; i < 5; i++) step("R6", 1'b1, 1'b0, 1'b0, 2'd0, '0);
        tprev = tout;
        step("R7", 1'b1, 1'b1, 1'b0, 2'd0, '0);
        check("R7", {31'd0, tout}, {31'd0, ~tprev});
        check("R6", {31'd0, irq}, 32'd1);
        step("R6", 1'b1, 1'b0, 1'b0, 2'd0, '0);
        check("R6", {31'd0, irq}, 32'd0);

        // R5 restart on edge, with edges on and off enabled cycles
        wr("R5", 2'd0, 8'h00);
        wr("R5", 2'd0, 8'h0A);
        wr("R5", 2'd1, 8'd200);
        for (int i = 0; i < 400; i++) step("R5", (i % 4) != 1, (i % 37) == 36 || (i % 53) == 0, 1'b0, 2'd0, '0);
        for (int i = 0; i < 300; i++) step("R5", 1'b1, 1'b0, 1'b0, 2'd0, '0);
        step("R5", 1'b0, 1'b1, 1'b0, 2'd0, '0);
        check("R5", {24'd0, count}, 32'd0);

        // R2 return to stop: counter zero, output frozen
        wr("R2", 2'd0, 8'h00);
        for (int i = 0; i < 10; i++) step("R2", 1'b1, 1'b1, 1'b0, 2'd0, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule